// File: doc/BRIEF.md
# Interrupt Status Field

This block is one multi-bit interrupt status field inside a register bank. It watches a hardware event vector on every rising edge of the register clock and turns it into status bits. A detection selector chooses what counts as an event on each bit: a high level, a rising edge, a falling edge, or either edge. Edges are found by comparing the present input with the value registered at the previous clock edge. A capture selector then chooses how events are recorded. Per-bit sticky capture sets and holds each bit. Whole-value capture freezes the complete input pattern the first time it becomes nonzero. Non-sticky capture simply registers the event vector every cycle.

Software clears recorded events by writing ones to the bits it wants to clear. Two independent reductions drive the outputs. The interrupt output ORs the status bits that its gate vector lets through. The halt output does the same with its own gate vector. Each gate vector can be read either as an enable (a 1 lets the bit through) or as a mask (a 1 blocks the bit). The bus protocol that carries the clear write, and any tree that combines interrupts from several registers, sit outside this block.

Top module: `irqStatusField`

## Requirements
- R1: Reset (asynchronous, active low on `rstN`) drives `status` to 0 and both `irqOut` and `haltOut` to 0. It also clears the edge history. So an input bit that is 1 at the first clock edge after reset counts as a rising edge.
- R2: With `detectMode` = 0 (level), every input bit that is 1 at a clock edge is an event on that bit.
- R3: With `detectMode` = 1, an event is an input bit that is 1 at this edge and was 0 at the previous edge. With `detectMode` = 2, it is a bit that is 0 now and was 1 before. With `detectMode` = 3, it is a bit whose value differs from the previous edge.
- R4: With `captureMode` = 0 (per-bit sticky), every event bit sets its status bit to 1. A set bit stays 1 until a clear write with a 1 in that bit position (`clrWrite` high, `clrData` bit = 1). Clear-data bits that are 0 leave their status bits unchanged.
- R5: With `captureMode` = 1 (whole-value sticky), when `status` is 0 and the event vector is nonzero, `status` takes the whole event vector. While `status` is nonzero, later events do not change it. A clear write removes the bits written as 1. Once `status` is 0 again, the next nonzero event vector is latched.
- R6: If an event and a clear hit the same bit at the same edge, the event wins. In per-bit mode the bit stays 1. In whole-value mode, a clear that would empty the field in the same cycle as a nonzero event vector leaves `status` equal to that event vector.
- R7: With `captureMode` = 2 or 3 (non-sticky), `status` equals the event vector detected at the most recent edge, and clear writes have no effect.
- R8: `irqOut` is 1 exactly when some bit is set in `status` and also passes `irqGate`. When `irqGateIsMask` = 0, a `irqGate` bit of 1 lets that bit through. When `irqGateIsMask` = 1, a bit of 1 blocks it.
- R9: `haltOut` follows the same rule as `irqOut` but uses its own `haltGate` and `haltGateIsMask`, independently of the interrupt gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous reset, active low |
| detectMode | input | 2 | Event detection: 0 level, 1 rising, 2 falling, 3 both edges |
| captureMode | input | 2 | Capture: 0 per-bit sticky, 1 whole-value sticky, 2/3 non-sticky |
| eventIn | input | WIDTH | Hardware event vector, synchronous to clk |
| clrWrite | input | 1 | Software write-one-to-clear strobe |
| clrData | input | WIDTH | Bits to clear when clrWrite is high |
| irqGate | input | WIDTH | Interrupt gate vector |
| irqGateIsMask | input | 1 | 0: irqGate is an enable, 1: irqGate is a mask |
| haltGate | input | WIDTH | Halt gate vector |
| haltGateIsMask | input | 1 | 0: haltGate is an enable, 1: haltGate is a mask |
| status | output | WIDTH | Interrupt status field |
| irqOut | output | 1 | Gated OR of status for interrupt |
| haltOut | output | 1 | Gated OR of status for halt |

## Verification
The hardest case to reach is an event and a clear landing on the same bit at the same edge. This is hardest in whole-value mode, where the clear must empty the field exactly when a new nonzero pattern arrives. Edge modes make it harder still, because the event depends on the previous cycle's input. The stimulus sweeps every pair of detection and capture modes. Inside each pair it drives pseudo-random input, clear and gate vectors, and a 4-bit field makes overlaps between clears and events frequent. A bench model keeps its own history and status, so every cycle's status and both outputs are compared. Cycles that contain such a collision are tagged separately.

// File: rtl/irqFieldPkg.sv
package irqFieldPkg;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } detectModeT;

  typedef enum logic [1:0] {
    CAP_BIT   = 2'd0,
    CAP_VALUE = 2'd1,
    CAP_PASS  = 2'd2,
    CAP_PASS2 = 2'd3
  } captureModeT;

  // strobes from control to datapath
  typedef struct packed {
    logic takeHigh;   // level event
    logic takeRise;   // 0->1 event
    logic takeFall;   // 1->0 event
    logic holdBits;   // per-bit sticky
    logic holdValue;  // whole-value sticky
    logic clearEn;    // apply clear mask this cycle
  } fieldCtrlT;

endpackage

// File: rtl/irqFieldCtrl.sv
module irqFieldCtrl
  import irqFieldPkg::*;
(
  input  logic [1:0] detectMode,
  input  logic [1:0] captureMode,
  input  logic       clrWrite,
  output fieldCtrlT  ctrl
);

  detectModeT  detSel;
  captureModeT capSel;

  assign detSel = detectModeT'(detectMode);
  assign capSel = captureModeT'(captureMode);

  always_comb begin
    ctrl = '0;
    unique case (detSel)
      DET_LEVEL: ctrl.takeHigh = 1'b1;
      DET_RISE:  ctrl.takeRise = 1'b1;
      DET_FALL:  ctrl.takeFall = 1'b1;
      DET_BOTH: begin
        ctrl.takeRise = 1'b1;
        ctrl.takeFall = 1'b1;
      end
      default: ctrl.takeHigh = 1'b1;
    endcase
    unique case (capSel)
      CAP_BIT:   ctrl.holdBits  = 1'b1;
      CAP_VALUE: ctrl.holdValue = 1'b1;
      default: begin
        ctrl.holdBits  = 1'b0;
        ctrl.holdValue = 1'b0;
      end
    endcase
    ctrl.clearEn = clrWrite & (ctrl.holdBits | ctrl.holdValue);
  end

endmodule

// File: rtl/irqFieldData.sv
module irqFieldData
  import irqFieldPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  fieldCtrlT        ctrl,
  input  logic [WIDTH-1:0] eventIn,
  input  logic [WIDTH-1:0] clrData,
  output logic [WIDTH-1:0] status
);

  logic [WIDTH-1:0] prevIn;
  logic [WIDTH-1:0] trig;
  logic [WIDTH-1:0] clrMask;
  logic [WIDTH-1:0] keptBits;
  logic [WIDTH-1:0] nextStatus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= eventIn;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : gBitDetect
    logic isHigh, isRise, isFall;
    assign isHigh  = eventIn[b];
    assign isRise  = eventIn[b] & ~prevIn[b];
    assign isFall  = ~eventIn[b] & prevIn[b];
    assign trig[b] = (ctrl.takeHigh & isHigh) |
                     (ctrl.takeRise & isRise) |
                     (ctrl.takeFall & isFall);
  end

  assign clrMask  = ctrl.clearEn ? clrData : '0;
  assign keptBits = status & ~clrMask;

  always_comb begin
    if (ctrl.holdBits) begin
      nextStatus = keptBits | trig;
    end else if (ctrl.holdValue) begin
      if (keptBits == '0 && trig != '0) nextStatus = trig;
      else                              nextStatus = keptBits;
    end else begin
      nextStatus = trig;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= nextStatus;
  end

endmodule

// File: rtl/irqFieldReduce.sv
module irqFieldReduce #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] status,
  input  logic [WIDTH-1:0] gate,
  input  logic             gateIsMask,
  output logic             hit
);

  logic [WIDTH-1:0] passBits;

  for (genvar b = 0; b < WIDTH; b++) begin : gGate
    assign passBits[b] = status[b] & (gate[b] ^ gateIsMask);
  end

  assign hit = |passBits;

endmodule

// File: rtl/irqStatusField.sv
module irqStatusField
  import irqFieldPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       detectMode,
  input  logic [1:0]       captureMode,
  input  logic [WIDTH-1:0] eventIn,
  input  logic             clrWrite,
  input  logic [WIDTH-1:0] clrData,
  input  logic [WIDTH-1:0] irqGate,
  input  logic             irqGateIsMask,
  input  logic [WIDTH-1:0] haltGate,
  input  logic             haltGateIsMask,
  output logic [WIDTH-1:0] status,
  output logic             irqOut,
  output logic             haltOut
);

  fieldCtrlT ctrl;

  irqFieldCtrl uCtrl (
    .detectMode (detectMode),
    .captureMode(captureMode),
    .clrWrite   (clrWrite),
    .ctrl       (ctrl)
  );

  irqFieldData #(.WIDTH(WIDTH)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .eventIn(eventIn),
    .clrData(clrData),
    .status (status)
  );

  irqFieldReduce #(.WIDTH(WIDTH)) uIrq (
    .status    (status),
    .gate      (irqGate),
    .gateIsMask(irqGateIsMask),
    .hit       (irqOut)
  );

  irqFieldReduce #(.WIDTH(WIDTH)) uHalt (
    .status    (status),
    .gate      (haltGate),
    .gateIsMask(haltGateIsMask),
    .hit       (haltOut)
  );

endmodule

// File: rtl/irqStatusFieldChecker.sv
module irqStatusFieldChecker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       detectMode,
  input logic [1:0]       captureMode,
  input logic [WIDTH-1:0] eventIn,
  input logic             clrWrite,
  input logic [WIDTH-1:0] irqGate,
  input logic             irqGateIsMask,
  input logic [WIDTH-1:0] haltGate,
  input logic             haltGateIsMask,
  input logic [WIDTH-1:0] status,
  input logic             irqOut,
  input logic             haltOut
);

  AST_LEVEL_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (captureMode[1] && detectMode == 2'd0) |=> status == $past(eventIn)); // R2

  AST_RISE_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    (captureMode[1] && detectMode == 2'd1) |=> (status & ~$past(eventIn)) == '0); // R3

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (captureMode == 2'd0 && !clrWrite) |=> (status & $past(status)) == $past(status)); // R4

  AST_VALUE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (captureMode == 2'd1 && status != '0 && !clrWrite) |=> $stable(status)); // R5

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (captureMode == 2'd0 && detectMode == 2'd0) |=> (status & $past(eventIn)) == $past(eventIn)); // R6

  AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rstN)
    (status == '0) |-> (!irqOut && !haltOut)); // R8

  AST_IRQ_NONE_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!irqGateIsMask && irqGate == '0) |-> !irqOut); // R8

  AST_HALT_ALL_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (haltGateIsMask && (&haltGate)) |-> !haltOut); // R9

endmodule

bind irqStatusField irqStatusFieldChecker #(.WIDTH(WIDTH)) uChecker (
  .clk           (clk),
  .rstN          (rstN),
  .detectMode    (detectMode),
  .captureMode   (captureMode),
  .eventIn       (eventIn),
  .clrWrite      (clrWrite),
  .irqGate       (irqGate),
  .irqGateIsMask (irqGateIsMask),
  .haltGate      (haltGate),
  .haltGateIsMask(haltGateIsMask),
  .status        (status),
  .irqOut        (irqOut),
  .haltOut       (haltOut)
);

// File: tb/irqStatusField_test.sv
`timescale 1ns/1ps
module irqStatusField_test;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   detectMode = 2'd0;
  logic [1:0]   captureMode = 2'd0;
  logic [W-1:0] eventIn = '0;
  logic         clrWrite = 1'b0;
  logic [W-1:0] clrData = '0;
  logic [W-1:0] irqGate = '0;
  logic         irqGateIsMask = 1'b0;
  logic [W-1:0] haltGate = '0;
  logic         haltGateIsMask = 1'b0;
  logic [W-1:0] status;
  logic         irqOut;
  logic         haltOut;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] mPrev = '0;
  logic [W-1:0] mStat = '0;
  logic [15:0]  lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  irqStatusField #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .detectMode(detectMode), .captureMode(captureMode),
    .eventIn(eventIn), .clrWrite(clrWrite), .clrData(clrData),
    .irqGate(irqGate), .irqGateIsMask(irqGateIsMask),
    .haltGate(haltGate), .haltGateIsMask(haltGateIsMask),
    .status(status), .irqOut(irqOut), .haltOut(haltOut)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] eventsOf(logic [1:0] d, logic [W-1:0] cur, logic [W-1:0] prv);
    case (d)
      2'd0:    return cur;
      2'd1:    return cur & ~prv;
      2'd2:    return ~cur & prv;
      default: return cur ^ prv;
    endcase
  endfunction

  function automatic logic gated(logic [W-1:0] s, logic [W-1:0] g, logic m);
    return |(s & (m ? ~g : g));
  endfunction

  // one clock edge: model next state, then compare after the edge
  task automatic step(input string tagIn);
    logic [W-1:0] ev, clr, kept, nxt;
    string tag;
    ev   = eventsOf(detectMode, eventIn, mPrev);
    clr  = (clrWrite && captureMode < 2) ? clrData : '0;
    kept = mStat & ~clr;
    if (captureMode == 2'd0)      nxt = kept | ev;
    else if (captureMode == 2'd1) nxt = (kept == '0 && ev != '0) ? ev : kept;
    else                          nxt = ev;
    tag = tagIn;
    if (tag == "") begin
      if (captureMode < 2 && (clr & ev) != '0) tag = "R6";
      else if (captureMode == 2'd0) tag = "R4";
      else if (captureMode == 2'd1) tag = "R5";
      else tag = "R7";
    end
    @(posedge clk);
    #1;
    mPrev = eventIn;
    mStat = nxt;
    chk(tag, "status", int'(status), int'(mStat));
    chk("R8", "irqOut", int'(irqOut), int'(gated(mStat, irqGate, irqGateIsMask)));
    chk("R9", "haltOut", int'(haltOut), int'(gated(mStat, haltGate, haltGateIsMask)));
  endtask

  task automatic drive(input logic [W-1:0] ev, input logic cw, input logic [W-1:0] cd);
    eventIn = ev; clrWrite = cw; clrData = cd;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    irqGate = '1;
    haltGate = '1;
    eventIn = 4'b1111;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "status in reset", int'(status), 0);
    chk("R1", "irqOut in reset", int'(irqOut), 0);
    chk("R1", "haltOut in reset", int'(haltOut), 0);
    eventIn = '0;
    @(negedge clk);
    rstN = 1'b1;
    mPrev = '0; mStat = '0;

    // R1: history cleared, so first high is a rising edge
    eventIn = 4'b1111;
    rstN = 1'b0; #1; rstN = 1'b1;
    mPrev = '0; mStat = '0;
    detectMode = 2'd1; captureMode = 2'd2;
    step("R1");
    chk("R1", "first edge after reset", int'(status), 4'b1111);

    // R2: level in non-sticky
    detectMode = 2'd0; drive(4'b0101, 1'b0, '0); step("R2");
    chk("R2", "level pattern", int'(status), 4'b0101);

    // R3: rise, fall, both
    detectMode = 2'd1; drive(4'b0111, 1'b0, '0); step("R3");
    chk("R3", "rising", int'(status), 4'b0010);
    detectMode = 2'd2; drive(4'b0001, 1'b0, '0); step("R3");
    chk("R3", "falling", int'(status), 4'b0110);
    detectMode = 2'd3; drive(4'b1000, 1'b0, '0); step("R3");
    chk("R3", "both edges", int'(status), 4'b1001);

    // R7: clear has no effect in non-sticky
    detectMode = 2'd0; drive(4'b1010, 1'b1, 4'b1111); step("R7");
    chk("R7", "clear ignored", int'(status), 4'b1010);

    // R4: per-bit sticky, partial clear
    captureMode = 2'd0; drive(4'b0000, 1'b0, '0); step("R4");
    chk("R4", "bits held", int'(status), 4'b1010);
    drive(4'b0001, 1'b1, 4'b0010); step("R4");
    chk("R4", "partial clear", int'(status), 4'b1001);

    // R6: collision in per-bit mode
    drive(4'b0001, 1'b1, 4'b1001); step("R6");
    chk("R6", "event beats clear", int'(status), 4'b0001);

    // R5/R6: whole-value latch
    drive(4'b0000, 1'b1, 4'b1111); step("R4");
    captureMode = 2'd1; drive(4'b0110, 1'b0, '0); step("R5");
    chk("R5", "latched", int'(status), 4'b0110);
    drive(4'b1001, 1'b0, '0); step("R5");
    chk("R5", "held against new", int'(status), 4'b0110);
    drive(4'b1001, 1'b1, 4'b0110); step("R6");
    chk("R6", "relatch on emptying clear", int'(status), 4'b1001);

    // R8/R9: gate polarities with status 1001
    drive(4'b0000, 1'b0, '0);
    irqGate = 4'b0001; irqGateIsMask = 1'b0; haltGate = 4'b1001; haltGateIsMask = 1'b1;
    step("R5");
    chk("R8", "enable hits", int'(irqOut), 1);
    chk("R9", "mask blocks all set", int'(haltOut), 0);
    irqGate = 4'b1001; irqGateIsMask = 1'b1; haltGate = 4'b0110; haltGateIsMask = 1'b1;
    #1;
    chk("R8", "mask blocks", int'(irqOut), 0);
    chk("R9", "mask passes", int'(haltOut), 1);

    // sweep all mode pairs with pseudo-random stimulus
    for (int d = 0; d < 4; d++) begin
      for (int c = 0; c < 4; c++) begin
        detectMode = 2'(d); captureMode = 2'(c);
        for (int k = 0; k < 80; k++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          eventIn = lfsr[3:0];
          clrWrite = lfsr[4] | lfsr[5];
          clrData = lfsr[9:6];
          irqGate = lfsr[13:10];
          irqGateIsMask = lfsr[14];
          haltGate = lfsr[7:4];
          haltGateIsMask = lfsr[15];
          step("");
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule